// File: doc/BRIEF.md
# Command-Driven I2C Master Engine

This block is the bus-facing engine of an I2C controller. It takes 11-bit command words from the head of a command queue and turns each one into bus activity. The word holds an operation code and a byte. The operations are: send a byte, emit a START or repeated START followed by an address byte, emit a STOP, and clock in a counted run of bytes. In a counted run the bytes are either pushed to the receive queue or thrown away. The engine drives SCL and SDA as open-drain enables. It steps one bit phase per strobe from an external timing generator, and each bit takes four strobes.

It keeps five status bits in fixed positions, which a register decoder can expose as-is. Three of them are sticky flags that are cleared by writing 1: STOP done, NACK seen and arbitration lost. The other two are live: master busy and bus busy. It also forms the receive read word from the receive queue's head byte and empty indication.

Top module: `i2c_cmd_engine`

## Requirements
- R1: A command word carries its code in bits 10:8 and a byte in bits 7:0. Codes 4 to 7 produce a START (or repeated START) and then send the byte MSB first as the address, with the read/write bit in bit 0. SDA changes while SCL is released only inside a START or a STOP.
- R2: Code 0 sends its byte MSB first and samples the acknowledge on the ninth clock. SCL changes only on cycles with the timing strobe high.
- R3: Code 1 receives (byte + 1) bytes, so one word covers 1 to 256 bytes. Each byte is presented on `rx_byte` with a one-cycle `rx_push`.
- R4: Code 3 clocks in (byte + 1) bytes the same way and never asserts `rx_push`.
- R5: In a counted run the master ACKs (drives SDA low) every byte. The exception is the last byte of the run, which it NACKs only when the command at the queue head at that moment is a STOP (code 2) or a START (codes 4-7).
- R6: Code 2 produces a STOP. On completion it sets status bit 9 and clears master busy (bit 24) and `hs_active`.
- R7: A NACK on a sent byte sets status bit 10. It is not set when the preceding START used code 5 or 7, or when `ignore_nack` is high.
- R8: While bit 10 is set, codes 0, 1 and 3 are not popped. Popping resumes once the bit is cleared.
- R9: If SDA reads low while the master is releasing it during a sent bit, status bit 11 is set and both enables drop. Master busy clears, and no command is popped until bit 11 is cleared.
- R10: A 1 in `flag_clr` bit 9, 10 or 11 clears the matching status flag.
- R11: Bus busy (bit 25) sets when a START is seen on the lines and clears when a STOP is seen. Master busy (bit 24) sets when a START command is taken.
- R12: `rxf_word` is 16'h4000 (bit 14 = empty) when the receive queue is empty. Otherwise it is the head byte in bits 7:0 with the other bits zero.
- R13: Codes 6 and 7 raise `hs_active`, which stays high until a STOP completes or arbitration is lost.
- R14: After reset all status bits are 0, both line enables are 0, and `cmd_pop` and `hs_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Bit-phase strobe from the timing generator |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_word | input | 11 | Command word at the queue head |
| cmd_pop | output | 1 | Removes the head command |
| rx_push | output | 1 | Received byte valid |
| rx_byte | output | 8 | Received byte |
| rxf_empty | input | 1 | Receive queue empty |
| rxf_head | input | 8 | Receive queue head byte |
| rxf_word | output | 16 | Receive read word |
| ignore_nack | input | 1 | Treat a NACK as an ACK |
| flag_clr | input | 32 | Write-1-to-clear mask for status flags |
| status | output | 32 | Status word |
| hs_active | output | 1 | High-speed START in use |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The engine has no parameters, so the bench builds it in its only configuration and sets the timing strobe to every second clock. At that rate a byte costs 72 clocks, which makes it cheap to sweep counted reads across run lengths of 1, 2, 3, 8 and 256 bytes. The 256-byte run exercises the full width of the count field. A bit-level target model on the wired-AND lines records every acknowledge the master gives. This lets the bench check the NACK placement against the following command for STOP, START and chained-receive neighbours. The receive read word is swept over every head byte value.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cmd_valid,
  input  logic [10:0] cmd_word,
  output logic        cmd_pop,
  output logic        rx_push,
  output logic [7:0]  rx_byte,
  input  logic        rxf_empty,
  input  logic [7:0]  rxf_head,
  output logic [15:0] rxf_word,
  input  logic        ignore_nack,
  input  logic [31:0] flag_clr,
  output logic [31:0] status,
  output logic        hs_active,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;
  st_t st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh, cnt;
  logic rx, disc, exp_nack, sdf, ndf, alf, mbf, bbf, sda_q, scl_q;
  logic [2:0] code;
  logic data_cmd, next_ends, ack_bit;

  assign code      = cmd_word[10:8];
  assign data_cmd  = (code == 3'd0) || (code == 3'd1) || (code == 3'd3);
  assign next_ends = cmd_valid && ((code == 3'd2) || code[2]);
  assign ack_bit   = (bitn == 4'd8);
  assign cmd_pop   = (st == S_IDLE) && cmd_valid && !alf && !(ndf && data_cmd);
  assign rx_push   = (st == S_BITS) && tick && (ph == 2'd3) && ack_bit && rx && !disc;
  assign rx_byte   = sh;
  assign rxf_word  = rxf_empty ? 16'h4000 : {8'h00, rxf_head};
  assign status    = {6'b0, bbf, mbf, 12'b0, alf, ndf, sdf, 9'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; bitn <= 4'd0; sh <= 8'd0; cnt <= 8'd0;
      rx <= 1'b0; disc <= 1'b0; exp_nack <= 1'b0; hs_active <= 1'b0;
      sdf <= 1'b0; ndf <= 1'b0; alf <= 1'b0; mbf <= 1'b0; bbf <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; sda_q <= 1'b1; scl_q <= 1'b1;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
      if (scl_in && scl_q && sda_q && !sda_in) bbf <= 1'b1;
      else if (scl_in && scl_q && !sda_q && sda_in) bbf <= 1'b0;
      if (flag_clr[9])  sdf <= 1'b0;
      if (flag_clr[10]) ndf <= 1'b0;
      if (flag_clr[11]) alf <= 1'b0;
      if (cmd_pop) begin
        ph <= 2'd0;
        bitn <= 4'd0;
        sh <= cmd_word[7:0];
        case (code)
          3'd0: begin st <= S_BITS; rx <= 1'b0; exp_nack <= 1'b0; end
          3'd1, 3'd3: begin
            st <= S_BITS; rx <= 1'b1; disc <= code[1]; cnt <= cmd_word[7:0];
          end
          3'd2: st <= S_STOP;
          default: begin
            st <= S_START; rx <= 1'b0; exp_nack <= code[0]; mbf <= 1'b1;
            if (code[1]) hs_active <= 1'b1;
          end
        endcase
      end else if (tick && st != S_IDLE) begin
        ph <= ph + 2'd1;
        case (st)
          S_START: begin
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin scl_oe <= 1'b1; st <= S_BITS; bitn <= 4'd0; end
            endcase
          end
          S_BITS: begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                sda_oe <= ack_bit ? (rx && !((cnt == 8'd0) && next_ends)) : (!rx && !sh[7]);
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (!ack_bit) begin
                  if (!rx && sh[7] && !sda_in) begin
                    alf <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
                    mbf <= 1'b0; hs_active <= 1'b0; st <= S_IDLE;
                  end else sh <= {sh[6:0], sda_in};
                end else if (!rx && sda_in && !ignore_nack && !exp_nack) ndf <= 1'b1;
              end
              default: begin
                scl_oe <= 1'b1;
                if (ack_bit) begin
                  if (rx && cnt != 8'd0) begin cnt <= cnt - 8'd1; bitn <= 4'd0; end
                  else st <= S_IDLE;
                end else bitn <= bitn + 4'd1;
              end
            endcase
          end
          S_STOP: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                sdf <= 1'b1; mbf <= 1'b0; hs_active <= 1'b0; st <= S_IDLE;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (st == S_START || st == S_STOP));
  a_r2_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(scl_oe));
  a_r6_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdf) |-> (!mbf && !hs_active));
  a_r9_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    alf |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_cmd_engine_bench.sv
`timescale 1ns/1ps
module i2c_cmd_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [10:0] q [0:63];
  int qh = 0, qt = 0;
  logic cmd_valid, cmd_pop, rx_push, rxf_empty, ignore_nack, hs_active;
  logic scl_in, sda_in, scl_oe, sda_oe;
  logic [10:0] cmd_word;
  logic [7:0] rx_byte, rxf_head;
  logic [15:0] rxf_word;
  logic [31:0] flag_clr, status, st_end;
  int checks = 0, errors = 0;

  logic ps = 1'b1, pc = 1'b1, first = 1'b0, stx = 1'b0, rw = 1'b0, mack_ok = 1'b0;
  logic slv_lo = 1'b0, force_lo = 1'b0, ack_en = 1'b1;
  logic [3:0] k = 4'd0;
  logic [7:0] sh_s = 8'd0, cur = 8'd0;
  int sn = 0, wn = 0, mn = 0, rxn = 0;
  logic [7:0] wlog [0:63];
  logic mack [0:511];
  logic [7:0] rxlog [0:511];

  always #2.5 clk = ~clk;

  assign cmd_valid = qh < qt;
  assign cmd_word  = q[qh[5:0]];
  assign scl_in    = !scl_oe;
  assign sda_in    = !(sda_oe || slv_lo || force_lo);

  i2c_cmd_engine u_i2c_cmd_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_pop(cmd_pop), .rx_push(rx_push), .rx_byte(rx_byte), .rxf_empty(rxf_empty),
    .rxf_head(rxf_head), .rxf_word(rxf_word), .ignore_nack(ignore_nack),
    .flag_clr(flag_clr), .status(status), .hs_active(hs_active), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe));

  function automatic logic [7:0] rdpat(input int n);
    return 8'(n * 29 + 7);
  endfunction

  always @(posedge clk) begin
    tick <= rst_n ? ~tick : 1'b0;
    if (cmd_pop) qh <= qh + 1;
    if (rx_push) begin rxlog[rxn] <= rx_byte; rxn <= rxn + 1; end
  end

  always @(posedge clk) begin
    ps <= sda_in;
    pc <= scl_in;
    if (pc && scl_in && ps && !sda_in) begin
      k <= 4'd0; first <= 1'b1; stx <= 1'b0; slv_lo <= 1'b0;
    end else if (pc && scl_in && !ps && sda_in) begin
      k <= 4'd0; stx <= 1'b0; slv_lo <= 1'b0;
    end else if (!pc && scl_in) begin
      if (k < 4'd8) sh_s <= {sh_s[6:0], sda_in};
      else if (stx) begin mack[mn] <= !sda_in; mn <= mn + 1; mack_ok <= !sda_in; end
      k <= k + 4'd1;
    end else if (pc && !scl_in) begin
      if (k == 4'd8) begin
        if (!stx) begin
          wlog[wn] <= sh_s; wn <= wn + 1; slv_lo <= ack_en;
          if (first) rw <= sh_s[0];
        end else slv_lo <= 1'b0;
      end else if (k == 4'd9) begin
        k <= 4'd0; first <= 1'b0;
        if ((first && rw) || (stx && mack_ok)) begin
          stx <= 1'b1; cur <= rdpat(sn); slv_lo <= !rdpat(sn)[7]; sn <= sn + 1;
        end else begin stx <= 1'b0; slv_lo <= 1'b0; end
      end else if (stx && k != 4'd0) slv_lo <= !cur[3'(4'd7 - k)];
    end
  end

  task automatic ce(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int code, input int data);
    q[qt[5:0]] = {3'(code), 8'(data)};
    qt = qt + 1;
  endtask

  task automatic clr(input logic [31:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = 32'd0;
  endtask

  task automatic finish_txn(input string req);
    int t = 0;
    while (!(qh == qt && status[9]) && t < 60000) begin @(negedge clk); t++; end
    ce({req, " stop reached"}, int'(t < 60000), 1);
    st_end = status;
    clr(32'h200);
  endtask

  task automatic read_run(input int c);
    int r0 = rxn, m0 = mn, s0 = sn;
    push(4, 8'hA1); push(1, c); push(2, 0);
    finish_txn("R3");
    ce("R3 byte count", rxn - r0, c + 1);
    for (int i = 0; i <= c; i++) begin
      ce("R3 data", int'(rxlog[r0 + i]), int'(rdpat(s0 + i)));
      ce("R5 ack pattern", int'(mack[m0 + i]), int'(i < c));
    end
  endtask

  initial begin
    int w0, m0, r0, cnts [5];
    cnts = '{0, 1, 2, 7, 255};
    rxf_empty = 1'b1; rxf_head = 8'd0; ignore_nack = 1'b0; flag_clr = 32'd0;
    repeat (4) @(negedge clk);
    ce("R14 status", int'(status), 0);
    ce("R14 lines", int'({scl_oe, sda_oe, cmd_pop, hs_active}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ce("R12 empty word", int'(rxf_word), 16'h4000);
    rxf_empty = 1'b0;
    for (int v = 0; v < 256; v++) begin
      rxf_head = 8'(v); #1;
      ce("R12 head word", int'(rxf_word), v);
    end
    rxf_empty = 1'b1;

    // R1 R2 R11 R6 R10: plain write
    w0 = wn;
    push(4, 8'hA0); push(0, 8'h12); push(0, 8'hFE); push(0, 8'h5B); push(2, 0);
    while (wn == w0) @(negedge clk);
    ce("R11 bus busy", int'(status[25]), 1);
    ce("R11 master busy", int'(status[24]), 1);
    finish_txn("R2");
    ce("R1 address", int'(wlog[w0]), 8'hA0);
    ce("R2 byte0", int'(wlog[w0 + 1]), 8'h12);
    ce("R2 byte1", int'(wlog[w0 + 2]), 8'hFE);
    ce("R2 byte2", int'(wlog[w0 + 3]), 8'h5B);
    ce("R6 stop flag", int'(st_end[9]), 1);
    ce("R6 busy clear", int'(st_end[24]), 0);
    ce("R11 bus free", int'(st_end[25]), 0);
    ce("R7 no nack", int'(st_end[10]), 0);
    ce("R10 cleared", int'(status), 0);

    for (int j = 0; j < 5; j++) read_run(cnts[j]);

    // R5 chained runs: ACK at the end of the first run
    m0 = mn;
    push(4, 8'hA1); push(1, 2); push(1, 1); push(2, 0);
    finish_txn("R5");
    for (int i = 0; i < 5; i++) ce("R5 chained ack", int'(mack[m0 + i]), int'(i < 4));
    // R5 NACK before repeated START
    m0 = mn;
    push(4, 8'hA1); push(1, 1); push(4, 8'hA1); push(1, 0); push(2, 0);
    finish_txn("R5");
    ce("R5 ack b0", int'(mack[m0]), 1);
    ce("R5 nack before start", int'(mack[m0 + 1]), 0);
    ce("R5 nack before stop", int'(mack[m0 + 2]), 0);

    // R4 discard
    r0 = rxn; m0 = mn;
    push(4, 8'hA1); push(3, 3); push(2, 0);
    finish_txn("R4");
    ce("R4 no push", rxn - r0, 0);
    ce("R4 bytes clocked", mn - m0, 4);

    // R7 R8 NACK blocks data commands
    ack_en = 1'b0; w0 = wn;
    push(4, 8'hA0); push(0, 8'h77); push(2, 0);
    while (wn == w0) @(negedge clk);
    repeat (400) @(negedge clk);
    ce("R7 nack flag", int'(status[10]), 1);
    ce("R8 data held", qt - qh, 2);
    clr(32'h400);
    finish_txn("R8");
    ce("R8 resumed", int'(wlog[w0 + 1]), 8'h77);
    ce("R7 data nack", int'(st_end[10]), 1);
    clr(32'h400);

    // R7 expected NACK and ignore
    push(5, 8'hA0); push(2, 0);
    finish_txn("R7");
    ce("R7 expected nack", int'(st_end[10]), 0);
    push(7, 8'hA0); push(2, 0);
    while (qh < qt - 1) @(negedge clk);
    repeat (2) @(negedge clk);
    ce("R13 hs code7", int'(hs_active), 1);
    finish_txn("R7");
    ce("R7 expected nack hs", int'(st_end[10]), 0);
    ce("R13 hs cleared", int'(hs_active), 0);
    ignore_nack = 1'b1; w0 = wn;
    push(4, 8'hA0); push(0, 8'h33); push(2, 0);
    finish_txn("R7");
    ce("R7 ignored", int'(st_end[10]), 0);
    ce("R7 ignored data", int'(wlog[w0 + 1]), 8'h33);
    ignore_nack = 1'b0; ack_en = 1'b1;

    // R13 code 6
    push(6, 8'hA0); push(0, 1); push(2, 0);
    while (qh < qt - 2) @(negedge clk);
    repeat (2) @(negedge clk);
    ce("R13 hs code6", int'(hs_active), 1);
    finish_txn("R13");
    ce("R13 hs off", int'(hs_active), 0);

    // R9 arbitration lost
    @(negedge clk) force_lo = 1'b1;
    push(4, 8'hFF); push(2, 0);
    repeat (300) @(negedge clk);
    ce("R9 lost flag", int'(status[11]), 1);
    ce("R9 lines released", int'({scl_oe, sda_oe}), 0);
    ce("R9 busy clear", int'(status[24]), 0);
    ce("R9 stop held", qt - qh, 1);
    force_lo = 1'b0;
    clr(32'h800);
    finish_txn("R9");
    ce("R10 lost cleared", int'(st_end[11]), 0);
    ce("R10 all clear", int'(status), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", qh, qt);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule